// File: doc/BRIEF.md
# Status Register Write Protection

This block holds the status byte of a small serial non-volatile memory and decides whether a memory write or a status write may proceed. A separate command decoder, which does the serial shifting, hands it one-cycle strobes: set or clear the write-enable latch, a completed status-write data byte, the chip-select rising edge, and a level that marks the current frame as a write-class command. The block also sees the hardware write-protect pin and the target address of a memory write.

Three mechanisms combine. The first is a write-enable latch that software sets before each write and that clears itself when a write-class frame ends. The second is a pair of block-protect bits that lock a fixed upper fraction of the array. The third is a protect-enable bit that, when set, lets a low level on the protect pin lock the status register. The protect bits and the protect-enable bit survive a functional reset. A load strobe restores them from their non-volatile copy.

Top module: `sr_protect_top`

## Requirements
- R1: A set-latch strobe sets the write-enable latch, seen in status bit 1 one cycle later.
- R2: A clear-latch strobe clears the latch one cycle later. If set and clear arrive in the same cycle, clear wins.
- R3: A chip-select rise while the write-class level is high clears the latch, whether or not any data was written. A chip-select rise without that level leaves the latch unchanged.
- R4: Status byte layout: protect-enable in bit 7, protect bits 1 and 0 in bits 3 and 2, latch in bit 1. Bits 6 to 4 and bit 0 always read 0.
- R5: memWriteOk is high only when the latch is set and the address lies outside the range the protect bits select. Code 00 protects nothing. Code 01 protects the top quarter (600h–7FFh at 11 address bits). Code 10 protects the top half (400h–7FFh). Code 11 protects the whole array.
- R6: statusWriteOk is high only when the latch is set and not both protect-enable is 1 and the protect pin is low.
- R7: A status-write strobe, when statusWriteOk is high, loads protect-enable from data bit 7 and the protect bits from data bits 3:2. The other data bits are ignored. When statusWriteOk is low, the strobe changes nothing.
- R8: Reset clears the latch and keeps protect-enable and the protect bits.
- R9: A load strobe copies data bits 7 and 3:2 into protect-enable and the protect bits in any state, including during reset. It wins over a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrenStb | input | 1 | Set write-enable latch |
| wrdiStb | input | 1 | Clear write-enable latch |
| wrCmdActive | input | 1 | Current frame is a write-class command |
| csRiseStb | input | 1 | Chip-select rising edge event |
| wrsrStb | input | 1 | Status-write data byte complete |
| wrsrData | input | 8 | Status-write data byte |
| nvLoadStb | input | 1 | Restore protect fields from non-volatile copy |
| nvLoadData | input | 8 | Non-volatile copy of the status byte |
| wpPin | input | 1 | Hardware protect pin, low means protect |
| addr | input | ADDR_W | Target address of a memory write |
| statusByte | output | 8 | Status byte for reading |
| memWriteOk | output | 1 | Memory write allowed at addr |
| statusWriteOk | output | 1 | Status write allowed |

## Verification
The hardest state to reach from the ports is a refused status write: the latch must be set while protect-enable is already 1 and the pin is low. The stimulus first sets the latch, writes protect-enable through an allowed status write, sets the latch again, pulls the pin low, and only then issues a status write whose data would change every field. Reset with non-default protect fields is reached the same way. The fields are programmed first and reset is asserted while the latch is set, so that keeping the protect fields and clearing the latch can be told apart.

// File: rtl/sr_protect_pkg.sv
package sr_protect_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStatus;  // accepted status write
    logic loadNv;      // restore from non-volatile copy
  } welCtl_t;

  localparam int unsigned WPEN_BIT = 7;
  localparam int unsigned BP_HI = 3;
  localparam int unsigned BP_LO = 2;
  localparam int unsigned WEL_BIT = 1;
endpackage

// File: rtl/sr_protect_ctl.sv
module sr_protect_ctl
  import sr_protect_pkg::*;
(
  input  logic    wrenStb,
  input  logic    wrdiStb,
  input  logic    wrCmdActive,
  input  logic    csRiseStb,
  input  logic    wrsrStb,
  input  logic    nvLoadStb,
  input  logic    wpPin,
  input  logic    wel,
  input  logic    wpen,
  output welCtl_t ctl,
  output logic    statusWriteOk
);
  logic pinLock;

  always_comb begin
    pinLock       = wpen && !wpPin;
    statusWriteOk = wel && !pinLock;
    ctl.setWel     = wrenStb;
    ctl.clrWel     = wrdiStb || (csRiseStb && wrCmdActive);
    ctl.loadNv     = nvLoadStb;
    ctl.loadStatus = wrsrStb && statusWriteOk && !nvLoadStb;
  end
endmodule

// File: rtl/sr_protect_dp.sv
module sr_protect_dp
  import sr_protect_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  welCtl_t           ctl,
  input  logic [7:0]        wrsrData,
  input  logic [7:0]        nvLoadData,
  input  logic [ADDR_W-1:0] addr,
  output logic              wel,
  output logic              wpen,
  output logic [7:0]        statusByte,
  output logic              memWriteOk
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(DEPTH / 2);

  logic [1:0] bp;
  logic [7:0] srcByte;
  logic       inRange;
  logic       unusedDataBits;

  assign srcByte = ctl.loadNv ? nvLoadData : wrsrData;
  assign unusedDataBits = ^{wrsrData[6:4], wrsrData[1:0], nvLoadData[6:4], nvLoadData[1:0]};

  // write-enable latch: clear has priority over set
  always_ff @(posedge clk) begin
    if (!rstN)           wel <= 1'b0;
    else if (ctl.clrWel) wel <= 1'b0;
    else if (ctl.setWel) wel <= 1'b1;
  end

  // protect fields are not touched by reset
  always_ff @(posedge clk) begin
    if (ctl.loadNv || (rstN && ctl.loadStatus)) begin
      wpen <= srcByte[WPEN_BIT];
      bp   <= srcByte[BP_HI:BP_LO];
    end
  end

  always_comb begin
    unique case (bp)
      2'b00:   inRange = 1'b0;
      2'b01:   inRange = (addr >= QTR_BASE);
      2'b10:   inRange = (addr >= HALF_BASE);
      default: inRange = 1'b1;
    endcase
  end

  assign memWriteOk = wel && !inRange;

  always_comb begin
    statusByte = '0;
    statusByte[WPEN_BIT]    = wpen;
    statusByte[BP_HI:BP_LO] = bp;
    statusByte[WEL_BIT]     = wel;
  end
endmodule

// File: rtl/sr_protect_top.sv
module sr_protect_top
  import sr_protect_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrenStb,
  input  logic              wrdiStb,
  input  logic              wrCmdActive,
  input  logic              csRiseStb,
  input  logic              wrsrStb,
  input  logic [7:0]        wrsrData,
  input  logic              nvLoadStb,
  input  logic [7:0]        nvLoadData,
  input  logic              wpPin,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        statusByte,
  output logic              memWriteOk,
  output logic              statusWriteOk
);
  welCtl_t ctl;
  logic    wel;
  logic    wpen;

  sr_protect_ctl u_ctl (
    .wrenStb(wrenStb), .wrdiStb(wrdiStb), .wrCmdActive(wrCmdActive),
    .csRiseStb(csRiseStb), .wrsrStb(wrsrStb), .nvLoadStb(nvLoadStb),
    .wpPin(wpPin), .wel(wel), .wpen(wpen), .ctl(ctl),
    .statusWriteOk(statusWriteOk)
  );

  sr_protect_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrsrData(wrsrData),
    .nvLoadData(nvLoadData), .addr(addr), .wel(wel), .wpen(wpen),
    .statusByte(statusByte), .memWriteOk(memWriteOk)
  );
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrenStb,
  input logic       wrdiStb,
  input logic       wrCmdActive,
  input logic       csRiseStb,
  input logic       wrsrStb,
  input logic       nvLoadStb,
  input logic       wpPin,
  input logic [7:0] statusByte,
  input logic       memWriteOk,
  input logic       statusWriteOk
);
  a_r1_set_latch: assert property (@(posedge clk) disable iff (!rstN)
    wrenStb && !wrdiStb && !(csRiseStb && wrCmdActive) |=> statusByte[1]);

  a_r2_clear_latch: assert property (@(posedge clk) disable iff (!rstN)
    wrdiStb |=> !statusByte[1]);

  a_r3_frame_end_clear: assert property (@(posedge clk) disable iff (!rstN)
    csRiseStb && wrCmdActive |=> !statusByte[1]);

  a_r4_fixed_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000 && !statusByte[0]);

  a_r5_full_lock: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:2] == 2'b11 |-> !memWriteOk);

  a_r5_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    memWriteOk |-> statusByte[1]);

  a_r6_pin_lock: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] && !wpPin |-> !statusWriteOk);

  a_r7_refused_stable: assert property (@(posedge clk) disable iff (!rstN)
    wrsrStb && !statusWriteOk && !nvLoadStb |=> $stable({statusByte[7], statusByte[3:2]}));
endmodule

bind sr_protect_top sr_protect_chk u_chk (
  .clk(clk), .rstN(rstN), .wrenStb(wrenStb), .wrdiStb(wrdiStb),
  .wrCmdActive(wrCmdActive), .csRiseStb(csRiseStb), .wrsrStb(wrsrStb),
  .nvLoadStb(nvLoadStb), .wpPin(wpPin), .statusByte(statusByte),
  .memWriteOk(memWriteOk), .statusWriteOk(statusWriteOk)
);

// File: tb/tb_sr_protect_top.sv
module tb_sr_protect_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrenStb = 0, wrdiStb = 0, wrCmdActive = 0, csRiseStb = 0;
  logic wrsrStb = 0, nvLoadStb = 0, wpPin = 1;
  logic [7:0] wrsrData = 0, nvLoadData = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic [7:0] statusByte;
  logic memWriteOk, statusWriteOk;

  int checks = 0;
  int errors = 0;
  bit mWel = 0, mWpen = 0;
  int mBp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_protect_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .wrenStb(wrenStb), .wrdiStb(wrdiStb),
    .wrCmdActive(wrCmdActive), .csRiseStb(csRiseStb), .wrsrStb(wrsrStb),
    .wrsrData(wrsrData), .nvLoadStb(nvLoadStb), .nvLoadData(nvLoadData),
    .wpPin(wpPin), .addr(addr), .statusByte(statusByte),
    .memWriteOk(memWriteOk), .statusWriteOk(statusWriteOk)
  );

  function automatic bit expLocked(int a);
    int depth = 1 << ADDR_W;
    case (mBp)
      0: return 0;
      1: return a >= depth * 3 / 4;
      2: return a >= depth / 2;
      default: return 1;
    endcase
  endfunction

  task automatic cmp(string tag);
    int expStatus = (mWpen ? 128 : 0) + mBp * 4 + (mWel ? 2 : 0);
    bit expSwo = mWel && !(mWpen && !wpPin);
    bit expMwo = mWel && !expLocked(int'(addr));
    checks += 3;
    if (statusByte !== 8'(expStatus)) begin
      errors++; $display("FAIL %s status act=%h exp=%h", tag, statusByte, 8'(expStatus));
    end
    if (statusWriteOk !== expSwo) begin
      errors++; $display("FAIL %s statusWriteOk act=%b exp=%b", tag, statusWriteOk, expSwo);
    end
    if (memWriteOk !== expMwo) begin
      errors++; $display("FAIL %s memWriteOk act=%b exp=%b addr=%h", tag, memWriteOk, expMwo, addr);
    end
  endtask

  // one clock: compare current outputs, advance the model at the edge
  task automatic step(string tag);
    bit swo;
    #1;
    if (rstN) cmp(tag);
    swo = mWel && !(mWpen && !wpPin);
    @(posedge clk);
    if (nvLoadStb) begin
      mWpen = nvLoadData[7]; mBp = int'(nvLoadData[3:2]);
    end else if (rstN && wrsrStb && swo) begin
      mWpen = wrsrData[7]; mBp = int'(wrsrData[3:2]);
    end
    if (!rstN) mWel = 0;
    else if (wrdiStb || (csRiseStb && wrCmdActive)) mWel = 0;
    else if (wrenStb) mWel = 1;
    @(negedge clk);
    wrenStb = 0; wrdiStb = 0; csRiseStb = 0; wrsrStb = 0; nvLoadStb = 0; wrCmdActive = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    nvLoadStb = 1; nvLoadData = 8'h00; step("R9");      // load during reset
    step("R8");
    rstN = 1; step("R8");                              // reset state
    addr = 11'h000; step("R5");                         // no latch, no write
    wrenStb = 1; step("R1");
    addr = 11'h7FF; step("R5");                         // bp 00 open
    wrsrStb = 1; wrsrData = 8'hFF; step("R7");           // wpen=1 bp=11
    addr = 11'h000; step("R4");
    step("R5");
    wrenStb = 1; step("R1");
    wpPin = 0; step("R6");
    wrsrStb = 1; wrsrData = 8'h00; step("R7");           // refused
    step("R7");
    wpPin = 1; step("R6");
    wrsrStb = 1; wrsrData = 8'h74; step("R7");           // wpen=0 bp=01, noise bits ignored
    addr = 11'h5FF; step("R5");
    addr = 11'h600; step("R5");
    csRiseStb = 1; step("R3");                           // no write frame: latch kept
    step("R3");
    csRiseStb = 1; wrCmdActive = 1; step("R3");          // write frame end: latch cleared
    step("R3");
    wrenStb = 1; wrdiStb = 1; step("R2");
    step("R2");
    wrenStb = 1; step("R1");
    wrdiStb = 1; step("R2");
    step("R2");
    wrenStb = 1; step("R1");
    wrsrStb = 1; wrsrData = 8'h88; step("R7");           // wpen=1 bp=10
    addr = 11'h3FF; step("R5");
    addr = 11'h400; step("R5");
    wrenStb = 1; step("R1");
    wpPin = 0; step("R6");
    wrenStb = 1; wrsrStb = 1; wrsrData = 8'h00; csRiseStb = 1; wrCmdActive = 1; step("R3");
    step("R3");
    wpPin = 1; wrenStb = 1; step("R1");
    rstN = 0; step("R8");
    rstN = 1; step("R8");                                // latch 0, fields kept
    nvLoadStb = 1; nvLoadData = 8'h04; step("R9");
    addr = 11'h7FF; step("R9");
    wrenStb = 1; step("R1");
    nvLoadStb = 1; nvLoadData = 8'h00; wrsrStb = 1; wrsrData = 8'h8C; step("R9");
    step("R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule